// File: doc/BRIEF.md
# Signalling Bit-Pair Slot Inserter

This block carries the two signalling bits that belong to every 8 kHz frame of a serial bearer link. It works in a single system clock domain. A one-cycle bit strobe marks each period of the serial bit clock, and a frame-sync input, qualified by that strobe, marks bit 0 of slot 0. Each frame holds `SLOTS` slots of 8 bits. In every frame the block inserts two outbound bits, supplied in parallel, and captures two inbound bits, which it returns in parallel together with a one-cycle valid pulse.

There are three routing modes. In multiplexed mode the outbound pair replaces two bearer bits on the line output, and the inbound pair is taken from the line input. In bit-clocked port mode the pair travels on a separate port pin pair, in step with the bit strobe, while the line output carries the bearer stream unchanged. In 16 kHz port mode the separate port is clocked by a continuous 16 kHz clock that the block derives from the bit strobe. That clock runs freely, has no relation to frame sync, and slot positions play no part in this mode.

The insert position and the capture position are programmed independently. Each one is a slot and an aligned bit-pair index. The programmed values, the routing mode and the outbound bits are all sampled at the frame boundary, so a pair is never split by an update.

Top module: `sig_pair_inserter`

## Requirements
- R1: After reset, line_out, sport_out, sclk16 and cap_valid are all 0.
- R2: A bit strobe with frame_sync high marks bit 0 of slot 0. Each later strobe moves one bit on. Slot s covers frame bits 8s..8s+7, and pair index p (0..3) covers bits 2p and 2p+1 of that slot.
- R3: In multiplexed mode, line_out carries ins_bits[1] at the first bit of the insert position and ins_bits[0] at the second. At every other bit it carries bearer_in. Each value is registered on the strobe of its own bit and becomes visible one clock later.
- R4: In multiplexed mode, line_in is sampled at the two bits of the capture position. The first bit goes to cap_bits[1] and the second to cap_bits[0]. cap_valid pulses for one clock after the second bit.
- R5: In bit-clocked port mode (mode_cfg=1), line_out equals bearer_in. sport_out carries the outbound pair at the insert position and is 0 elsewhere. The capture comes from sport_in at the capture position.
- R6: sclk16 toggles on every 2*SLOTS-th bit strobe counted from reset, in every mode, whatever frame_sync does.
- R7: In 16 kHz port mode (mode_cfg=2), line_out equals bearer_in. On each rising sclk16 edge, sport_out presents ins_bits[1] and ins_bits[0] in turn, with both bits sampled at the rise that carries bit 1. sport_in is sampled on falling edges, and cap_valid pulses after every second falling edge, with the earlier bit in cap_bits[1].
- R8: The slot, pair and mode inputs and ins_bits are sampled only at a frame boundary. A change in the middle of a frame takes effect from the next frame_sync.
- R9: mode_cfg code 3 behaves exactly like code 0, the multiplexed mode.
- R10: In multiplexed mode sport_out stays 0 and sport_in is ignored. In bit-clocked port mode line_in is ignored.
- R11: In the slot-based modes cap_valid pulses exactly once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per serial bit period |
| frame_sync | input | 1 | With bit_en, marks bit 0 of slot 0 |
| mode_cfg | input | 2 | 0/3 multiplexed, 1 bit-clocked port, 2 16 kHz port |
| cap_slot_cfg | input | 6 | Capture slot number |
| cap_pair_cfg | input | 2 | Capture pair index inside the slot |
| ins_slot_cfg | input | 6 | Insert slot number |
| ins_pair_cfg | input | 2 | Insert pair index inside the slot |
| ins_bits | input | 2 | Outbound pair, bit 1 sent first |
| bearer_in | input | 1 | Bearer bit for the current bit period |
| line_in | input | 1 | Serial line input |
| line_out | output | 1 | Serial line output |
| sport_in | input | 1 | Separate signalling port input |
| sport_out | output | 1 | Separate signalling port output |
| sclk16 | output | 1 | Free-running 16 kHz port clock |
| cap_bits | output | 2 | Captured pair, first bit in bit 1 |
| cap_valid | output | 1 | One-cycle pulse when cap_bits is updated |

## Verification
The bench sweeps every one of the 64 capture positions of a 16-slot frame, and at the same time walks the insert position through a scrambled order, in both multiplexed codes and in bit-clocked port mode. A position decoder that is off by one bit, or that reverses the pair order, then corrupts line_out or cap_bits in a frame it can name. The configuration and the outbound bits are changed in the middle of each frame, often to a position later in that same frame. A block that applied updates at once would insert a second pair or split one. The 16 kHz section uses frames of irregular length, so a divider that restarted on frame_sync would toggle at the wrong strobe count. It also checks that the bits alternate on sclk16 edges with slot settings ignored, and that the port and line inputs not selected are driven with noise that must never reach a capture.

// File: rtl/sig_pair_pkg.sv
package sig_pair_pkg;

  localparam int CFG_SLOT_W = 6;

  typedef enum logic [1:0] {
    MODE_MUX      = 2'd0,
    MODE_PORT_BIT = 2'd1,
    MODE_PORT_16K = 2'd2,
    MODE_MUX_ALT  = 2'd3
  } sp_mode_e;

  typedef struct packed {
    logic [CFG_SLOT_W-1:0] slot;
    logic [1:0]            pair;
  } sp_pos_t;

  typedef struct packed {
    sp_mode_e mode;
    sp_pos_t  cap;
    sp_pos_t  ins;
  } sp_cfg_t;

  // Both multiplexed codes share one behaviour.
  function automatic logic is_mux_mode(sp_mode_e m);
    return (m == MODE_MUX) || (m == MODE_MUX_ALT);
  endfunction

  function automatic logic is_16k_mode(sp_mode_e m);
    return m == MODE_PORT_16K;
  endfunction

  // True when (slot, bit-in-slot) lies inside the aligned pair of p.
  function automatic logic in_pair(logic [CFG_SLOT_W-1:0] slot,
                                   logic [2:0] bitn, sp_pos_t p);
    return (slot == p.slot) && (bitn[2:1] == p.pair);
  endfunction

  // Earlier bit of a pair travels in bit 1.
  function automatic logic pair_bit(logic [1:0] pair, logic second);
    return second ? pair[0] : pair[1];
  endfunction

endpackage

// File: rtl/sp_frame_pos.sv
module sp_frame_pos
  import sig_pair_pkg::*;
#(
  parameter int SLOTS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  frame_sync,
  input  sp_cfg_t               cfg_in,
  input  logic [1:0]            ins_in,
  output logic [CFG_SLOT_W-1:0] cur_slot,
  output logic [2:0]            cur_bit,
  output logic                  synced,
  output sp_cfg_t               cfg_eff,
  output sp_cfg_t               cfg_act,
  output logic [1:0]            ins_eff
);

  localparam int FRAME_BITS = SLOTS * 8;
  localparam int POS_W      = $clog2(FRAME_BITS);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] cur_pos;
  logic             frame_start;
  logic             synced_q;
  sp_cfg_t          cfg_q;
  logic [1:0]       ins_q;

  function automatic logic [POS_W-1:0] next_pos(logic [POS_W-1:0] p, logic restart);
    if (restart) return '0;
    if (p == POS_W'(FRAME_BITS - 1)) return '0;
    return POS_W'(p + 1'b1);
  endfunction

  assign frame_start = bit_en & frame_sync;
  assign cur_pos     = next_pos(pos_q, frame_sync);
  assign cur_slot    = CFG_SLOT_W'(cur_pos[POS_W-1:3]);
  assign cur_bit     = cur_pos[2:0];
  assign synced      = synced_q | frame_start;

  // The boundary bit already uses the freshly sampled settings.
  assign cfg_eff = frame_start ? cfg_in : cfg_q;
  assign ins_eff = frame_start ? ins_in : ins_q;
  assign cfg_act = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      synced_q <= 1'b0;
      cfg_q    <= '{mode: MODE_MUX, cap: '0, ins: '0};
      ins_q    <= '0;
    end else if (bit_en) begin
      pos_q <= cur_pos;
      if (frame_sync) begin
        synced_q <= 1'b1;
        cfg_q    <= cfg_in;
        ins_q    <= ins_in;
      end
    end
  end

endmodule

// File: rtl/sp_slot_path.sv
module sp_slot_path
  import sig_pair_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  active,
  input  logic                  mux_sel,
  input  logic [CFG_SLOT_W-1:0] cur_slot,
  input  logic [2:0]            cur_bit,
  input  sp_pos_t               cap_pos,
  input  sp_pos_t               ins_pos,
  input  logic [1:0]            ins_pair,
  input  logic                  bearer_in,
  input  logic                  line_in,
  input  logic                  sport_in,
  output logic                  line_out,
  output logic                  sport_out,
  output logic [1:0]            cap_bits,
  output logic                  cap_valid
);

  logic ins_hit;
  logic cap_hit;
  logic ins_bit;
  logic cap_src;
  logic first_q;

  assign ins_hit = active & in_pair(cur_slot, cur_bit, ins_pos);
  assign cap_hit = active & in_pair(cur_slot, cur_bit, cap_pos);
  assign ins_bit = pair_bit(ins_pair, cur_bit[0]);
  assign cap_src = mux_sel ? line_in : sport_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_out  <= 1'b0;
      sport_out <= 1'b0;
    end else if (bit_en) begin
      line_out  <= (ins_hit && mux_sel) ? ins_bit : bearer_in;
      sport_out <= (ins_hit && !mux_sel) ? ins_bit : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q   <= 1'b0;
      cap_bits  <= '0;
      cap_valid <= 1'b0;
    end else begin
      cap_valid <= 1'b0;
      if (bit_en && cap_hit) begin
        if (!cur_bit[0]) begin
          first_q <= cap_src;
        end else begin
          cap_bits  <= {first_q, cap_src};
          cap_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sp_dclk_path.sv
module sp_dclk_path #(
  parameter int HALF_DIV = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       enable,
  input  logic [1:0] ins_bits,
  input  logic       sport_in,
  output logic       sclk16,
  output logic       sport_out,
  output logic [1:0] cap_bits,
  output logic       cap_valid
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic             term;
  logic             rise_evt;
  logic             fall_evt;
  logic             idx_q;
  logic [1:0]       hold_q;
  logic             first_q;

  assign term     = bit_en && (div_q == DIV_W'(HALF_DIV - 1));
  assign rise_evt = term & ~sclk16;
  assign fall_evt = term & sclk16;

  // Free-running divider: frame sync never touches it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk16 <= 1'b0;
      idx_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (bit_en) div_q <= term ? '0 : DIV_W'(div_q + 1'b1);
      if (term) sclk16 <= ~sclk16;
      if (fall_evt) idx_q <= ~idx_q;
      if (rise_evt && !idx_q) hold_q <= ins_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sport_out <= 1'b0;
      first_q   <= 1'b0;
      cap_bits  <= '0;
      cap_valid <= 1'b0;
    end else begin
      cap_valid <= 1'b0;
      if (!enable) begin
        sport_out <= 1'b0;
      end else begin
        if (rise_evt) sport_out <= idx_q ? hold_q[0] : ins_bits[1];
        if (fall_evt) begin
          if (!idx_q) begin
            first_q <= sport_in;
          end else begin
            cap_bits  <= {first_q, sport_in};
            cap_valid <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/sig_pair_inserter.sv
module sig_pair_inserter
  import sig_pair_pkg::*;
#(
  parameter int SLOTS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       frame_sync,
  input  logic [1:0] mode_cfg,
  input  logic [5:0] cap_slot_cfg,
  input  logic [1:0] cap_pair_cfg,
  input  logic [5:0] ins_slot_cfg,
  input  logic [1:0] ins_pair_cfg,
  input  logic [1:0] ins_bits,
  input  logic       bearer_in,
  input  logic       line_in,
  output logic       line_out,
  input  logic       sport_in,
  output logic       sport_out,
  output logic       sclk16,
  output logic [1:0] cap_bits,
  output logic       cap_valid
);

  // One 16 kHz period spans half a frame of bit strobes.
  localparam int HALF_DIV = SLOTS * 2;

  sp_cfg_t               cfg_in;
  sp_cfg_t               cfg_eff;
  sp_cfg_t               cfg_act;
  logic [1:0]            ins_eff;
  logic [CFG_SLOT_W-1:0] cur_slot;
  logic [2:0]            cur_bit;
  logic                  synced;
  logic                  slot_active;
  logic                  mux_sel;
  logic                  mode16_act;
  logic [1:0]            bit_mode;
  logic                  s_sport;
  logic [1:0]            s_cap;
  logic                  s_valid;
  logic                  d_sport;
  logic [1:0]            d_cap;
  logic                  d_valid;

  assign cfg_in = '{mode: sp_mode_e'(mode_cfg),
                    cap:  '{slot: cap_slot_cfg, pair: cap_pair_cfg},
                    ins:  '{slot: ins_slot_cfg, pair: ins_pair_cfg}};

  sp_frame_pos #(.SLOTS(SLOTS)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .frame_sync(frame_sync),
    .cfg_in    (cfg_in),
    .ins_in    (ins_bits),
    .cur_slot  (cur_slot),
    .cur_bit   (cur_bit),
    .synced    (synced),
    .cfg_eff   (cfg_eff),
    .cfg_act   (cfg_act),
    .ins_eff   (ins_eff)
  );

  assign bit_mode    = cfg_eff.mode;
  assign mux_sel     = is_mux_mode(cfg_eff.mode);
  assign slot_active = synced & ~is_16k_mode(cfg_eff.mode);
  assign mode16_act  = is_16k_mode(cfg_act.mode);

  sp_slot_path u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .active   (slot_active),
    .mux_sel  (mux_sel),
    .cur_slot (cur_slot),
    .cur_bit  (cur_bit),
    .cap_pos  (cfg_eff.cap),
    .ins_pos  (cfg_eff.ins),
    .ins_pair (ins_eff),
    .bearer_in(bearer_in),
    .line_in  (line_in),
    .sport_in (sport_in),
    .line_out (line_out),
    .sport_out(s_sport),
    .cap_bits (s_cap),
    .cap_valid(s_valid)
  );

  sp_dclk_path #(.HALF_DIV(HALF_DIV)) u_dclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .enable   (mode16_act),
    .ins_bits (ins_bits),
    .sport_in (sport_in),
    .sclk16   (sclk16),
    .sport_out(d_sport),
    .cap_bits (d_cap),
    .cap_valid(d_valid)
  );

  assign sport_out = mode16_act ? d_sport : s_sport;
  assign cap_bits  = mode16_act ? d_cap : s_cap;
  assign cap_valid = s_valid | d_valid;

endmodule

// File: rtl/sig_pair_checker.sv
module sig_pair_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       bearer_in,
  input logic       line_out,
  input logic       sport_out,
  input logic       sclk16,
  input logic       cap_valid,
  input logic [1:0] bit_mode
);

  logic mux_now;
  assign mux_now = (bit_mode == 2'd0) || (bit_mode == 2'd3);

  AST_LINE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_out)); // R3

  AST_CAP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> !cap_valid); // R4

  AST_PORT_MODE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !mux_now) |=> (line_out == $past(bearer_in))); // R5

  AST_SCLK_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(sclk16)); // R6

  AST_SPORT_IDLE_IN_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mux_now) |=> !sport_out); // R10

endmodule

bind sig_pair_inserter sig_pair_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_en   (bit_en),
  .bearer_in(bearer_in),
  .line_out (line_out),
  .sport_out(sport_out),
  .sclk16   (sclk16),
  .cap_valid(cap_valid),
  .bit_mode (bit_mode)
);

// File: tb/sig_pair_inserter_bench.sv
module sig_pair_inserter_bench;

  localparam int SLOTS = 16;
  localparam int FB    = SLOTS * 8;
  localparam int HALF  = SLOTS * 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, frame_sync = 1'b0;
  logic [1:0] mode_cfg = 2'd0;
  logic [5:0] cap_slot_cfg = '0, ins_slot_cfg = '0;
  logic [1:0] cap_pair_cfg = '0, ins_pair_cfg = '0, ins_bits = '0;
  logic       bearer_in = 1'b0, line_in = 1'b0, sport_in = 1'b0;
  logic       line_out, sport_out, sclk16, cap_valid;
  logic [1:0] cap_bits;

  sig_pair_inserter #(.SLOTS(SLOTS)) u_sig_pair_inserter (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync),
    .mode_cfg(mode_cfg), .cap_slot_cfg(cap_slot_cfg), .cap_pair_cfg(cap_pair_cfg),
    .ins_slot_cfg(ins_slot_cfg), .ins_pair_cfg(ins_pair_cfg), .ins_bits(ins_bits),
    .bearer_in(bearer_in), .line_in(line_in), .line_out(line_out),
    .sport_in(sport_in), .sport_out(sport_out), .sclk16(sclk16),
    .cap_bits(cap_bits), .cap_valid(cap_valid)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // expected (current frame) and next-frame settings
  int e_mode, e_cs, e_cp, e_is, e_ip; logic [1:0] e_ins;
  int n_mode, n_cs, n_cp, n_is, n_ip; logic [1:0] n_ins;

  logic [15:0] lfsr = 16'hACE1;
  logic s_line, s_sport, s_valid; logic [1:0] s_cap;
  int total_bits = 0, rcount = 0;
  logic prev_sclk = 1'b0;
  logic [1:0] held = '0, ins_drv = '0;
  int sclk_err = 0, sclk_tog = 0, d_err = 0, d_chk = 0, c16_err = 0, c16_chk = 0;
  bit m16 = 1'b0, f0_seen = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic next_rand(output logic b);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    b = lfsr[0];
  endtask

  function automatic logic pat(int n);
    return ((n * 5) % 7) < 3;
  endfunction

  task automatic bit_step(input logic fs_v);
    logic ex;
    @(negedge clk);
    frame_sync = fs_v; bit_en = 1'b1;
    if (m16) sport_in = pat(rcount - 1);
    @(negedge clk);
    bit_en = 1'b0; frame_sync = 1'b0;
    total_bits++;
    s_line = line_out; s_sport = sport_out; s_valid = cap_valid; s_cap = cap_bits;
    // R6: toggle exactly on each HALF-th strobe from reset
    if (sclk16 !== prev_sclk) begin
      sclk_tog++;
      if (total_bits % HALF != 0) sclk_err++;
    end else if (total_bits % HALF == 0) sclk_err++;
    if (sclk16 && !prev_sclk) begin
      if (m16) begin
        d_chk++;
        ex = (rcount % 2 == 0) ? ins_drv[1] : held[0];
        if (sport_out !== ex) d_err++;
      end
      if (rcount % 2 == 0) held = ins_drv;
      rcount++;
    end
    if (!sclk16 && prev_sclk && m16 && ((rcount - 1) % 2 == 0)) f0_seen = 1'b1;
    if (cap_valid && m16 && f0_seen) begin
      c16_chk++;
      if (cap_bits !== {pat(rcount - 2), pat(rcount - 1)}) c16_err++;
    end
    prev_sclk = sclk16;
  endtask

  task automatic set_next(input int mode, input int idx);
    int j;
    j = (idx * 37 + 11) % 64;
    n_mode = mode; n_cs = (idx % 64) / 4; n_cp = idx % 4;
    n_is = j / 4; n_ip = j % 4; n_ins = 2'(idx % 4);
  endtask

  task automatic run_frame(input int len);
    int err_line = 0, err_sport = 0, err_cap = 0, nvalid = 0;
    logic cf = 1'b0;
    logic [1:0] exp_cap = '0;
    bit is_mux;
    is_mux = (e_mode == 0) || (e_mode == 3);
    for (int b = 0; b < len; b++) begin
      logic bl, li, si, ih, ib, ch, src, el, es;
      int slot, bt;
      next_rand(bl); next_rand(li); next_rand(si);
      bearer_in = bl; line_in = li;
      if (!m16) sport_in = si;
      if (b == 40) begin   // R8: mid-frame update, must wait for next sync
        mode_cfg = 2'(n_mode); cap_slot_cfg = 6'(n_cs); cap_pair_cfg = 2'(n_cp);
        ins_slot_cfg = 6'(n_is); ins_pair_cfg = 2'(n_ip);
        ins_bits = n_ins; ins_drv = n_ins;
      end
      bit_step(b == 0);
      if (b == 0 && e_mode == 2) m16 = 1'b1;
      slot = b / 8; bt = b % 8;
      ih = (slot == e_is) && (bt / 2 == e_ip);
      ib = (bt % 2 == 1) ? e_ins[0] : e_ins[1];
      ch = (slot == e_cs) && (bt / 2 == e_cp);
      src = is_mux ? li : si;
      if (is_mux) begin el = ih ? ib : bl; es = 1'b0; end
      else begin el = bl; es = ih ? ib : 1'b0; end
      if (s_line !== el) err_line++;
      if (e_mode != 2 && s_sport !== es) err_sport++;
      if (ch && e_mode != 2) begin
        if (bt % 2 == 0) cf = src; else exp_cap = {cf, src};
      end
      if (s_valid && e_mode != 2) begin
        nvalid++;
        if (s_cap !== exp_cap) err_cap++;
      end
    end
    if (is_mux) begin
      check(err_line == 0, "R2 R3 R8 R9", "mux line_out bit errors", err_line, 0);
      check(err_sport == 0, "R10", "sport_out nonzero in mux", err_sport, 0);
      check(nvalid == 1, "R11", "captures in frame", nvalid, 1);
      check(err_cap == 0, "R4 R10", "mux capture errors", err_cap, 0);
    end else if (e_mode == 1) begin
      check(err_line == 0, "R5", "port-mode line_out errors", err_line, 0);
      check(err_sport == 0, "R5 R8", "port sport_out bit errors", err_sport, 0);
      check(nvalid == 1, "R11", "captures in frame", nvalid, 1);
      check(err_cap == 0, "R5 R10", "port capture errors", err_cap, 0);
    end else begin
      check(err_line == 0, "R7", "16k-mode line_out errors", err_line, 0);
    end
    e_mode = n_mode; e_cs = n_cs; e_cp = n_cp; e_is = n_is; e_ip = n_ip; e_ins = n_ins;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    set_next(0, 0);
    e_mode = n_mode; e_cs = n_cs; e_cp = n_cp; e_is = n_is; e_ip = n_ip; e_ins = n_ins;
    mode_cfg = 2'(e_mode); cap_slot_cfg = 6'(e_cs); cap_pair_cfg = 2'(e_cp);
    ins_slot_cfg = 6'(e_is); ins_pair_cfg = 2'(e_ip); ins_bits = e_ins; ins_drv = e_ins;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(line_out === 1'b0, "R1", "line_out after reset", int'(line_out), 0);
    check(sport_out === 1'b0, "R1", "sport_out after reset", int'(sport_out), 0);
    check(sclk16 === 1'b0, "R1", "sclk16 after reset", int'(sclk16), 0);
    check(cap_valid === 1'b0, "R1", "cap_valid after reset", int'(cap_valid), 0);

    // multiplexed sweep, alternating codes 0 and 3 (R9)
    for (int k = 0; k < 64; k++) begin
      set_next((k == 63) ? 1 : (((k + 1) % 2 == 1) ? 3 : 0), k + 1);
      run_frame(FB);
    end
    // bit-clocked port sweep
    for (int k = 0; k < 32; k++) begin
      set_next((k == 31) ? 2 : 1, (k == 31) ? 6 : k * 2 + 1);
      run_frame(FB);
    end
    // 16 kHz mode, irregular frame lengths
    for (int k = 0; k < 10; k++) begin
      set_next(2, 6);
      run_frame((k % 2 == 1) ? 100 : FB);
    end

    check(sclk_err == 0 && sclk_tog > 10, "R6", "sclk16 toggle timing errors", sclk_err, 0);
    check(d_err == 0 && d_chk >= 4, "R7", "16k sport_out bit errors", d_err, 0);
    check(c16_err == 0 && c16_chk >= 2, "R7", "16k capture errors", c16_err, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule